// File: doc/BRIEF.md
# Power-Fail Write-Protect Gate with Battery-Low Lockout

This block sits between a byte-wide asynchronous SRAM bus and the storage array behind it. It turns the active-low chip select, output enable and write enable strobes into three internal controls: a write strobe for the array, a read enable for the array and a drive enable for the data bus. A power-fail indication from a supply monitor forces the whole bus into a deselected state, with every output off and every strobe ignored.

A battery-condition input is sampled once, on the first clock edge after reset. If the battery is reported weak, a sticky lockout flag is set. The flag blocks one write attempt. That attempt is the one that proves the flag to software, because the written data never lands. The flag clears once that attempt ends, and later writes go through normally. The flag is brought out as a status pin. Reads never clear it.

The power-fail input is asynchronous and passes through a reset-to-failed synchronizer. The gate therefore stays deselected during reset and for the synchronizer depth after reset.

Top module: `pfg_gate`

## Requirements
- R1: With chip select low, output enable low, write enable high and no power fail, `dq_oe` and `mem_re` are 1 and `mem_we` is 0.
- R2: With chip select high, all three outputs are 0 whatever the other strobes are. With chip select low and both output enable and write enable high, `mem_re` is 1 while `dq_oe` and `mem_we` are 0.
- R3: With no power fail and the lockout flag clear, `mem_we` is 1 exactly while chip select and write enable are both low. It opens at the later of their falling edges and closes at the earlier of their rising edges.
- R4: While a write is in progress, `dq_oe` is 0 even when output enable is low.
- R5: When `pwr_fail` is sampled high on two consecutive rising edges (SYNC_STAGES = 2), all outputs are 0 from the second edge on. This includes a write already open, which is cut off.
- R6: When `pwr_fail` is sampled low on two consecutive rising edges, normal decoding resumes from the second edge on.
- R7: `batt_bad` is 0 in reset and takes the value of `batt_low` at the first rising edge after reset. Later changes of `batt_low` have no effect on it.
- R8: While `batt_bad` is 1, a write attempt (chip select and write enable both low, no power fail) gives `mem_we` = 0. `batt_bad` falls at the first rising edge at which the attempt is no longer present. The next write attempt drives `mem_we` to 1.
- R9: Reads do not clear `batt_bad`. Strobes given while power fail is in effect do not count as a write attempt.
- R10: During reset and until the second rising edge after reset release, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_fail | input | 1 | Asynchronous supply-out-of-tolerance indication, active high |
| batt_low | input | 1 | Battery-weak indication, sampled once after reset |
| mem_we | output | 1 | Internal array write strobe |
| mem_re | output | 1 | Internal array read enable |
| dq_oe | output | 1 | Data bus drive enable |
| batt_bad | output | 1 | Battery-low lockout flag |

## Verification
The hardest state to reach is the lockout flag set and still pending, because it is loaded only on the single edge after reset. The bench therefore runs a second reset with `batt_low` high. Within that one window it performs reads, then strobes a write under power fail, then makes the real attempt. This shows that only a genuine attempt consumes the flag. A separate case opens a write and then raises power fail while the strobes stay low, so the cut-off of a write in progress is observed at `mem_we`.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_READ  = 2'd1,
        MODE_PEND  = 2'd2,
        MODE_WRITE = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic done;
        logic flag;
        logic wr_prev;
    } lock_state_t;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int W = (STAGES < 1) ? 1 : STAGES;

    logic [W-1:0] chain_d, chain_q;
    logic [W:0]   ext;

    always_comb begin
        ext     = {chain_q, d_i};
        chain_d = ext[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {W{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[W-1];
endmodule

// File: rtl/pfg_decode.sv
module pfg_decode
    import pfg_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      blocked,
    output bus_mode_e mode
);
    always_comb begin
        if (blocked || ce_n)  mode = MODE_IDLE;
        else if (!we_n)       mode = MODE_WRITE;
        else if (!oe_n)       mode = MODE_READ;
        else                  mode = MODE_PEND;
    end
endmodule

// File: rtl/pfg_lockout.sv
module pfg_lockout
    import pfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic batt_low,
    input  logic attempt,
    output logic flag
);
    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.done = 1'b1;
            st_d.flag = batt_low;
        end else if (st_q.flag && st_q.wr_prev && !attempt) begin
            st_d.flag = 1'b0;
        end
        st_d.wr_prev = attempt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
    import pfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic pwr_fail,
    input  logic batt_low,
    output logic mem_we,
    output logic mem_re,
    output logic dq_oe,
    output logic batt_bad
);
    logic      pf_s;
    bus_mode_e mode;
    logic      attempt;
    logic      lock;

    pfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pwr_fail),
        .q_o   (pf_s)
    );

    pfg_decode u_dec (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .blocked (pf_s),
        .mode    (mode)
    );

    assign attempt = (mode == MODE_WRITE);

    pfg_lockout u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .batt_low (batt_low),
        .attempt  (attempt),
        .flag     (lock)
    );

    always_comb begin
        mem_we   = attempt && !lock;
        mem_re   = (mode == MODE_READ) || (mode == MODE_PEND);
        dq_oe    = (mode == MODE_READ);
        batt_bad = lock;
    end
endmodule

// File: rtl/pfg_gate_chk.sv
module pfg_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic pwr_fail,
    input logic mem_we,
    input logic mem_re,
    input logic dq_oe,
    input logic batt_bad
);
    logic [1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           seen_q <= '0;
        else if (seen_q != 2) seen_q <= seen_q + 2'd1;
    end

    a_r1_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && !oe_n && we_n));

    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!mem_we && !mem_re && !dq_oe));

    a_r4_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !dq_oe);

    a_r5_power_fail_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_fail) && $past(pwr_fail, 2)) |-> (!mem_we && !mem_re && !dq_oe));

    a_r7_flag_loads_once: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_bad) |-> (seen_q == 2'd1));

    a_r8_lock_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        batt_bad |-> !mem_we);

    a_r8_clear_after_attempt: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(batt_bad) |-> $past(!ce_n && !we_n, 2));
endmodule

bind pfg_gate pfg_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .pwr_fail (pwr_fail),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .dq_oe    (dq_oe),
    .batt_bad (batt_bad)
);

// File: tb/sim_pfg_gate.sv
module sim_pfg_gate;
    logic clk = 1'b0;
    logic rst_n, ce_n, oe_n, we_n, pwr_fail, batt_low;
    logic mem_we, mem_re, dq_oe, batt_bad;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pfg_gate u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pwr_fail(pwr_fail), .batt_low(batt_low),
        .mem_we(mem_we), .mem_re(mem_re), .dq_oe(dq_oe), .batt_bad(batt_bad)
    );

    // {ce_n, oe_n, we_n, exp mem_we, exp mem_re, exp dq_oe}
    localparam logic [5:0] VEC [8] = '{
        6'b100_000,   // R2 deselect ignores strobes
        6'b111_000,   // R2 idle
        6'b001_011,   // R1 read
        6'b011_010,   // R2 selected, no output
        6'b010_100,   // R3 write
        6'b000_100,   // R4 write with oe low
        6'b110_000,   // R3 write enable alone
        6'b001_011    // R1 read again
    };

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {mem_we, mem_re, dq_oe, batt_bad};
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic strobes(input logic c, input logic o, input logic w);
        ce_n = c; oe_n = o; we_n = w;
        #1;
    endtask

    task automatic do_reset(input logic bl);
        @(negedge clk);
        rst_n = 1'b0; batt_low = bl; pwr_fail = 1'b0;
        strobes(1'b0, 1'b0, 1'b1);
        cyc(3);
        chk("R10 outputs off in reset", outs(), 4'b0000);
        rst_n = 1'b1;
        #1;
        chk("R10 off after release", outs(), 4'b0000);
        cyc(1);
        chk("R10 off after first edge", {outs()[3:1], 1'b0}, 4'b0000);
        cyc(1);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        pwr_fail = 1'b0; batt_low = 1'b0;

        // good battery
        do_reset(1'b0);
        chk("R10 read resumes after second edge", outs(), 4'b0110);
        chk("R7 flag clear with good battery", {3'b0, batt_bad}, 4'b0000);
        batt_low = 1'b1;  // R7 late change ignored
        for (int k = 0; k < 8; k++) begin
            strobes(VEC[k][5], VEC[k][4], VEC[k][3]);
            chk($sformatf("R1 R2 R3 R4 vector %0d", k), outs(), {VEC[k][2:0], 1'b0});
            cyc(1);
        end
        chk("R7 late batt_low ignored", {3'b0, batt_bad}, 4'b0000);

        // power fail timing on a read
        strobes(1'b0, 1'b0, 1'b1);
        pwr_fail = 1'b1;
        cyc(1);
        chk("R5 still active after one edge", outs(), 4'b0110);
        cyc(1);
        chk("R5 deselected after two edges", outs(), 4'b0000);
        strobes(1'b0, 1'b1, 1'b0);
        chk("R5 write ignored in power fail", outs(), 4'b0000);
        strobes(1'b0, 1'b0, 1'b1);
        pwr_fail = 1'b0;
        cyc(1);
        chk("R6 still off after one edge", outs(), 4'b0000);
        cyc(1);
        chk("R6 read resumes after two edges", outs(), 4'b0110);

        // write in progress cut off
        strobes(1'b0, 1'b1, 1'b0);
        chk("R3 write open", outs(), 4'b1000);
        pwr_fail = 1'b1;
        cyc(2);
        chk("R5 open write cut off", outs(), 4'b0000);
        pwr_fail = 1'b0;
        strobes(1'b1, 1'b1, 1'b1);
        cyc(3);

        // weak battery
        do_reset(1'b1);
        chk("R7 flag set from sample", outs(), 4'b0111);
        batt_low = 1'b0;
        strobes(1'b0, 1'b1, 1'b1);
        cyc(3);
        chk("R9 reads keep flag", outs(), 4'b0101);

        // strobes under power fail are not an attempt
        strobes(1'b1, 1'b1, 1'b1);
        pwr_fail = 1'b1;
        cyc(3);
        strobes(1'b0, 1'b1, 1'b0);
        cyc(2);
        strobes(1'b1, 1'b1, 1'b1);
        cyc(1);
        pwr_fail = 1'b0;
        cyc(3);
        chk("R9 power-fail write not counted", outs(), 4'b0001);

        // real attempt blocked, then flag clears
        strobes(1'b0, 1'b0, 1'b0);
        chk("R8 first write blocked", outs(), 4'b0001);
        cyc(2);
        chk("R8 flag held during attempt", outs(), 4'b0001);
        strobes(1'b1, 1'b1, 1'b1);
        chk("R8 flag before clearing edge", outs(), 4'b0001);
        cyc(1);
        chk("R8 flag cleared after attempt", outs(), 4'b0000);
        strobes(1'b0, 1'b1, 1'b0);
        chk("R8 second write passes", outs(), 4'b1000);
        cyc(1);
        strobes(1'b1, 1'b1, 1'b1);
        cyc(1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule